// File: doc/BRIEF.md
# Three-Oscillator Sine Stimulus Generator

This block produces digital sine stimulus for on-chip analog functional testing. It holds three phase-accumulator oscillators. Each has its own tuning word and phase offset word, and each yields one signed sine sample per clock from a sine table that is built at elaboration.

Two oscillators, A and B, form the stimulus. In single-tone mode oscillator A alone drives the converter port, which suits frequency-response and noise measurements. In dual-tone mode A and B are summed and halved, which suits intermodulation (third-order intercept) measurements with closely spaced tones.

The third oscillator, R, feeds the response analyzer with a reference tone. A restart pulse zeroes all three accumulators on the same edge, so the stimulus and the reference start from a known phase relation. A sweep controller adds a programmable step to the frequency of both A and R after every programmable number of samples, so the band of interest is covered one frequency at a time.

Top module: `dds_tpg`

## Requirements
- R1: While reset is low and on the first cycles after it, dac_out, ref_out and step_done are 0, and sweep_ftw equals ftw_a.
- R2: In single-tone mode (two_tone=0), dac_out is the sample of oscillator A. Sample n after a restart is S((acc_n[23:14] + ph_a) mod 1024), where acc_n = n·fa mod 2^24 and S(k) = round(2047·sin(2πk/1024)), rounded half away from zero.
- R3: In dual-tone mode (two_tone=1), dac_out is floor((sA + sB)/2), computed in 13-bit signed arithmetic, where sB uses ftw_b and ph_b in the same way as R2.
- R4: ref_out follows the R2 formula with the reference frequency fr and ph_r, and the two_tone setting has no effect on it.
- R5: The phase offset word is added to the top 10 accumulator bits modulo 1024, so offsets near 1023 wrap to the start of the table.
- R6: A restart that is high at a clock edge zeroes all three accumulators. The first sample after the restart appears after the next edge and equals S(ph) for each oscillator.
- R7: With sweep_en low, the sweep offset is zero, so sweep_ftw = ftw_a, fa = ftw_a, fr = ftw_r, and step_done stays 0.
- R8: With sweep_en high and dwell ≥ 2, step_done pulses for one cycle after every dwell-th edge, counted from the first edge with sweep_en high. On that edge sweep_step is added to the offset that both fa and fr carry, and sweep_ftw shows ftw_a plus the offset.
- R9: A dwell of 0 or 1 makes step_done high after every edge, and the offset advances on every edge.
- R10: dac_out and ref_out never leave the range -2047..2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Zeroes all accumulators at the edge |
| two_tone | input | 1 | 0: tone A only, 1: (A+B)/2 |
| ftw_a | input | 24 | Start tuning word of tone A |
| ftw_b | input | 24 | Tuning word of tone B |
| ftw_r | input | 24 | Start tuning word of the reference |
| ph_a | input | 10 | Phase offset of tone A |
| ph_b | input | 10 | Phase offset of tone B |
| ph_r | input | 10 | Phase offset of the reference |
| sweep_en | input | 1 | Enables stepping; low clears the offset |
| sweep_step | input | 24 | Offset increment per step |
| dwell | input | 16 | Samples per frequency point |
| dac_out | output | 12 | Signed stimulus sample |
| ref_out | output | 12 | Signed reference sample |
| step_done | output | 1 | One-cycle strobe when a step is taken |
| sweep_ftw | output | 24 | Current stimulus tuning word |

## Verification
Each sample comes from a table read registered one edge after the accumulator. Sample n after a restart therefore appears after edge n+1 counted from the restart edge. The bench keeps its own accumulator model in step with this and compares at the falling edge that follows. The mode select reaches dac_out without a register, so a change of two_tone is checked in the same cycle. step_done and sweep_ftw change on the dwell-th edge after sweep_en rises, and the bench counts edges and compares after each one.

// File: rtl/dds_tpg.sv
module dds_tpg #(
  parameter int ACC_W   = 24,
  parameter int IDX_W   = 10,
  parameter int SAMP_W  = 12,
  parameter int DWELL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              two_tone,
  input  logic [ACC_W-1:0]  ftw_a,
  input  logic [ACC_W-1:0]  ftw_b,
  input  logic [ACC_W-1:0]  ftw_r,
  input  logic [IDX_W-1:0]  ph_a,
  input  logic [IDX_W-1:0]  ph_b,
  input  logic [IDX_W-1:0]  ph_r,
  input  logic              sweep_en,
  input  logic [ACC_W-1:0]  sweep_step,
  input  logic [DWELL_W-1:0] dwell,
  output logic [SAMP_W-1:0] dac_out,
  output logic [SAMP_W-1:0] ref_out,
  output logic              step_done,
  output logic [ACC_W-1:0]  sweep_ftw
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int AMP   = (1 << (SAMP_W - 1)) - 1;

  function automatic logic [SAMP_W-1:0] sin_at(input int k);
    real v;
    int  r;
    v = real'(AMP) * $sin(2.0 * 3.14159265358979 * real'(k) / real'(DEPTH));
    r = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
    return SAMP_W'(r);
  endfunction

  logic [SAMP_W-1:0] rom [DEPTH];
  for (genvar k = 0; k < DEPTH; k++) begin : g_rom
    assign rom[k] = sin_at(k);
  end

  logic [ACC_W-1:0]   acc_a, acc_b, acc_r, ofs;
  logic [DWELL_W-1:0] cnt;
  logic [SAMP_W-1:0]  s_a, s_b, s_r;

  wire [ACC_W-1:0] fa = ftw_a + ofs;
  wire [ACC_W-1:0] fr = ftw_r + ofs;
  wire [IDX_W-1:0] ia = acc_a[ACC_W-1 -: IDX_W] + ph_a;
  wire [IDX_W-1:0] ib = acc_b[ACC_W-1 -: IDX_W] + ph_b;
  wire [IDX_W-1:0] ir = acc_r[ACC_W-1 -: IDX_W] + ph_r;
  wire last = (dwell <= DWELL_W'(1)) || (cnt == dwell - DWELL_W'(1));
  wire [SAMP_W:0] sum = {s_a[SAMP_W-1], s_a} + {s_b[SAMP_W-1], s_b};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_a <= '0; acc_b <= '0; acc_r <= '0;
      s_a <= '0; s_b <= '0; s_r <= '0;
    end else begin
      if (restart) begin
        acc_a <= '0; acc_b <= '0; acc_r <= '0;
      end else begin
        acc_a <= acc_a + fa;
        acc_b <= acc_b + ftw_b;
        acc_r <= acc_r + fr;
      end
      s_a <= rom[ia];
      s_b <= rom[ib];
      s_r <= rom[ir];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !sweep_en) begin
      cnt <= '0; ofs <= '0; step_done <= 1'b0;
    end else if (last) begin
      cnt <= '0; ofs <= ofs + sweep_step; step_done <= 1'b1;
    end else begin
      cnt <= cnt + DWELL_W'(1); step_done <= 1'b0;
    end
  end

  assign dac_out   = two_tone ? sum[SAMP_W:1] : s_a;
  assign ref_out   = s_r;
  assign sweep_ftw = fa;
endmodule

module dds_tpg_chk #(
  parameter int ACC_W  = 24,
  parameter int SAMP_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              restart,
  input logic              sweep_en,
  input logic              step_done,
  input logic [ACC_W-1:0]  ftw_a,
  input logic [ACC_W-1:0]  sweep_step,
  input logic [ACC_W-1:0]  sweep_ftw,
  input logic [ACC_W-1:0]  acc_a,
  input logic [ACC_W-1:0]  acc_b,
  input logic [ACC_W-1:0]  acc_r,
  input logic [SAMP_W-1:0] dac_out,
  input logic [SAMP_W-1:0] ref_out
);
  localparam int AMP = (1 << (SAMP_W - 1)) - 1;

  p_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(dac_out) <= AMP) && ($signed(dac_out) >= -AMP) &&
    ($signed(ref_out) <= AMP) && ($signed(ref_out) >= -AMP));

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (acc_a == '0) && (acc_b == '0) && (acc_r == '0));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sweep_en |=> !step_done);

  p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && $stable(ftw_a) && $past(sweep_en) && $past(step_done) == 1'b0
     && $stable(sweep_step)) |-> (sweep_ftw == $past(sweep_ftw) + sweep_step));

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (step_done == 1'b0));
endmodule

bind dds_tpg dds_tpg_chk #(.ACC_W(ACC_W), .SAMP_W(SAMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .sweep_en(sweep_en),
  .step_done(step_done), .ftw_a(ftw_a), .sweep_step(sweep_step),
  .sweep_ftw(sweep_ftw), .acc_a(acc_a), .acc_b(acc_b), .acc_r(acc_r),
  .dac_out(dac_out), .ref_out(ref_out));

// File: tb/sim_dds_tpg.sv
module sim_dds_tpg;
  logic clk = 0, rst_n = 0, restart = 0, two_tone = 0, sweep_en = 0;
  logic [23:0] ftw_a = 0, ftw_b = 0, ftw_r = 0, sweep_step = 0;
  logic [9:0]  ph_a = 0, ph_b = 0, ph_r = 0;
  logic [15:0] dwell = 0;
  logic [11:0] dac_out, ref_out;
  logic        step_done;
  logic [23:0] sweep_ftw;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dds_tpg u0 (.clk, .rst_n, .restart, .two_tone, .ftw_a, .ftw_b, .ftw_r,
    .ph_a, .ph_b, .ph_r, .sweep_en, .sweep_step, .dwell,
    .dac_out, .ref_out, .step_done, .sweep_ftw);

  localparam int NV = 5;
  localparam logic        V_TT [NV] = '{0, 1, 0, 1, 0};
  localparam logic [23:0] V_FA [NV] = '{24'h010000, 24'h040000, 24'h003333, 24'h0A1234, 24'hFFC000};
  localparam logic [23:0] V_FB [NV] = '{24'h020000, 24'h044000, 24'h000100, 24'h0A9000, 24'h123456};
  localparam logic [23:0] V_FR [NV] = '{24'h010000, 24'h050000, 24'h070000, 24'h000000, 24'h3FFFFF};
  localparam logic [9:0]  V_PA [NV] = '{0, 100, 1023, 256, 1020};
  localparam logic [9:0]  V_PB [NV] = '{0, 512, 5, 1023, 7};
  localparam logic [9:0]  V_PR [NV] = '{0, 256, 1022, 3, 768};

  function automatic int sn(input int k);
    real v;
    v = 2047.0 * $sin(2.0 * 3.14159265358979 * real'(k & 1023) / 1024.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
  endfunction

  function automatic int tone(input logic [23:0] acc, input logic [9:0] ph);
    logic [9:0] i;
    i = acc[23:14] + ph;
    return sn(int'(i));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_restart;
    restart = 1;
    @(negedge clk);
    restart = 0;
  endtask

  task automatic run_tone(input int n, input logic [23:0] fa, input logic [23:0] fr);
    logic [23:0] aa, ab, ar;
    int ea, eb;
    aa = 0; ab = 0; ar = 0;
    pulse_restart();
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ea = tone(aa, ph_a);
      eb = tone(ab, ph_b);
      if (two_tone) chk("R3 dual", int'($signed(dac_out)), (ea + eb) >>> 1);
      else          chk("R2 single", int'($signed(dac_out)), ea);
      chk("R4 ref", int'($signed(ref_out)), tone(ar, ph_r));
      aa = aa + fa; ab = ab + ftw_b; ar = ar + fr;
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 dac reset", int'(dac_out), 0);
    chk("R1 ref reset", int'(ref_out), 0);
    chk("R1 step reset", int'(step_done), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ftw after reset", int'(sweep_ftw), int'(ftw_a));

    for (int v = 0; v < NV; v++) begin
      two_tone = V_TT[v]; ftw_a = V_FA[v]; ftw_b = V_FB[v]; ftw_r = V_FR[v];
      ph_a = V_PA[v]; ph_b = V_PB[v]; ph_r = V_PR[v];
      run_tone(12, ftw_a, ftw_r);
    end

    // R6 R5: first sample equals S(ph), with wrapping offsets
    ftw_a = 24'h0ABCDE; ftw_b = 24'h055555; ftw_r = 24'h012345;
    ph_a = 1023; ph_b = 511; ph_r = 1;
    two_tone = 0;
    pulse_restart();
    @(negedge clk);
    chk("R6 first A", int'($signed(dac_out)), sn(1023));
    chk("R6 first ref", int'($signed(ref_out)), sn(1));
    // R4: mode change leaves ref alone, R3 dual combinational
    two_tone = 1;
    #1;
    chk("R4 ref mode", int'($signed(ref_out)), sn(1));
    chk("R3 same cycle", int'($signed(dac_out)), (sn(1023) + sn(511)) >>> 1);
    two_tone = 0;

    // R7: sweep idle
    repeat (5) begin
      @(negedge clk);
      chk("R7 no strobe", int'(step_done), 0);
      chk("R7 ftw", int'(sweep_ftw), int'(ftw_a));
    end

    // R8: dwell 3
    ftw_a = 24'h010000; ftw_r = 24'h020000; sweep_step = 24'h008000; dwell = 3;
    sweep_en = 1;
    for (int e = 0; e < 6; e++) begin
      @(negedge clk);
      chk("R8 strobe", int'(step_done), (e % 3 == 2) ? 1 : 0);
      chk("R8 ftw", int'(sweep_ftw), int'(24'h010000 + 24'h008000 * ((e + 1) / 3)));
    end
    // freeze the offset at two steps and check both tones carry it
    dwell = 16'd60000;
    run_tone(10, 24'h020000, 24'h030000);

    // R9: dwell 0 and 1
    sweep_en = 0;
    @(negedge clk);
    chk("R7 cleared", int'(sweep_ftw), int'(ftw_a));
    dwell = 0; sweep_en = 1;
    for (int e = 0; e < 3; e++) begin
      @(negedge clk);
      chk("R9 dwell0 strobe", int'(step_done), 1);
      chk("R9 dwell0 ftw", int'(sweep_ftw), int'(24'h010000 + 24'h008000 * (e + 1)));
    end
    sweep_en = 0; @(negedge clk);
    dwell = 1; sweep_en = 1;
    for (int e = 0; e < 3; e++) begin
      @(negedge clk);
      chk("R9 dwell1 strobe", int'(step_done), 1);
    end
    sweep_en = 0;

    // R1: reset mid-run
    rst_n = 0;
    @(negedge clk);
    chk("R1 dac again", int'(dac_out), 0);
    chk("R1 ref again", int'(ref_out), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule